// File: doc/BRIEF.md
# SDRAM Bank Configuration Register File

This block holds the configuration state of a four-bank SDRAM controller. Software reaches it through two words: a pointer word and a data window. A write with the pointer selected stores an internal register offset. A read or write with the window selected then acts on the register at that offset. Writes take effect at the next rising clock edge. Reads are combinational from the current state.

The register set covers two error status words, an error address, a global configuration, a read-only status, a refresh timer, a power-management timer, one configuration word per bank, a timing word, an ECC configuration and an ECC error status. Each register applies its own write mask, and some also force fixed bits.

From the bank words the block decodes, for each bank, a base address, a size and an active flag. A bank is active only while the global enable is set. For a request address, the block reports which active bank claims it, and the lowest-numbered bank wins on overlap. A single interrupt line reflects whether the ECC error status holds any bit.

Top module: `sdram_cfg_regs`

## Requirements
- R1: After reset, reads return configuration 0x00800000, refresh timer 0x05F00000, power-management timer 0x07C00000 and zero for the pointer, status, error address and ECC error registers. The timing output is 0x00854009, and the interrupt and all bank active flags are 0.
- R2: A write with `acc_sel`=0 stores the pointer, which reads back with `acc_sel`=0. With `acc_sel`=1, reads and writes act on the register at the pointer offset: 0x00/0x08 error status, 0x10 error address, 0x20 configuration, 0x24 status, 0x30 refresh, 0x34 power management, 0x40+4·n bank n, 0x80 timing, 0x94 ECC configuration, 0x98 ECC error.
- R3: The two error status words are write-one-to-clear. The error address stores the written word unchanged. A write to the status register has no effect, and neither does a write to an undefined offset.
- R4: A configuration write stores the data ANDed with 0xFFE00000. Bit 31 is the global enable.
- R5: When configuration bit 31 goes 0→1, status bit 31 clears. When it goes 1→0, status bit 31 sets.
- R6: When configuration bit 30 goes 0→1, status bit 30 sets. When it goes 1→0, status bit 30 clears.
- R7: A bank write stores the data ANDed with 0xFFDEE001. Bit 0 is valid. The base is the word ANDed with 0xFF800000. The size is 0x00400000 shifted left by bits [19:17], and a field value of 7 gives size 0.
- R8: A bank's active flag is 1 exactly when its valid bit and configuration bit 31 are both 1.
- R9: Refresh-timer writes are masked with 0x3FF80000. Power-management writes keep bits [31:27] and always read with 0x07C00000 set. Timing writes are masked with 0x018FC01F and drive `tmg_cfg`. ECC configuration writes are masked with 0x00F00000.
- R10: An ECC error write stores the data ANDed with 0xFFF0F000. The interrupt rises the cycle after a write that turns the register from zero to nonzero, and falls the cycle after a write that turns it from nonzero to zero.
- R11: A window read at the timing offset or at any undefined offset returns 0xFFFFFFFF.
- R12: `bank_hit` is one-hot or zero. It marks the lowest-numbered active bank with nonzero size where base ≤ `req_addr` < base+size.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_sel | input | 1 | 0 selects the pointer word, 1 selects the data window |
| acc_we | input | 1 | Write strobe for the selected word |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data of the selected word |
| req_addr | input | 32 | Request address for bank lookup |
| bank_base | output | NUM_BANKS×32 | Decoded base per bank |
| bank_size | output | NUM_BANKS×32 | Decoded size per bank, 0 if invalid |
| bank_active | output | NUM_BANKS | Bank mapping active |
| bank_hit | output | NUM_BANKS | One-hot owner of `req_addr` |
| tmg_cfg | output | 32 | Stored timing word |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
Two functions can land in the same clock edge: a configuration write that clears the global enable, and a bank lookup in progress on a steady request address. To provoke this, the bench holds an address that bank 0 claims and issues the disabling write. In the write cycle it samples `bank_hit`, which must still show bank 0. After the edge it requires no hit, no active bank and status bit 31 set. The ECC interrupt is judged the same way, one cycle after each write that crosses the zero boundary.

// File: rtl/sdcfg_pkg.sv
package sdcfg_pkg;
  localparam int RW = 32;
  typedef logic [RW-1:0] word_t;

  // internal offsets
  localparam word_t OFS_ERR0  = 32'h00;
  localparam word_t OFS_ERR1  = 32'h08;
  localparam word_t OFS_EADDR = 32'h10;
  localparam word_t OFS_CFG   = 32'h20;
  localparam word_t OFS_STAT  = 32'h24;
  localparam word_t OFS_RTR   = 32'h30;
  localparam word_t OFS_PMIT  = 32'h34;
  localparam word_t OFS_BANK0 = 32'h40;
  localparam word_t OFS_TMG   = 32'h80;
  localparam word_t OFS_ECCC  = 32'h94;
  localparam word_t OFS_ECCE  = 32'h98;

  // write masks and forced bits
  localparam word_t MSK_CFG   = 32'hFFE0_0000;
  localparam word_t MSK_BANK  = 32'hFFDE_E001;
  localparam word_t MSK_BASE  = 32'hFF80_0000;
  localparam word_t MSK_RTR   = 32'h3FF8_0000;
  localparam word_t MSK_PMIT  = 32'hF800_0000;
  localparam word_t SET_PMIT  = 32'h07C0_0000;
  localparam word_t MSK_TMG   = 32'h018F_C01F;
  localparam word_t MSK_ECCC  = 32'h00F0_0000;
  localparam word_t MSK_ECCE  = 32'hFFF0_F000;

  // reset values
  localparam word_t RST_CFG   = 32'h0080_0000;
  localparam word_t RST_RTR   = 32'h05F0_0000;
  localparam word_t RST_PMIT  = 32'h07C0_0000;
  localparam word_t RST_TMG   = 32'h0085_4009;

  localparam word_t UNIT_SIZE = 32'h0040_0000;
  localparam word_t ALL_ONES  = 32'hFFFF_FFFF;

  localparam int EN_BIT  = 31;
  localparam int SLF_BIT = 30;
endpackage

// File: rtl/sdcfg_bank_dec.sv
module sdcfg_bank_dec
  import sdcfg_pkg::*;
(
  input  word_t bank_q,
  input  logic  glb_en,
  input  word_t req_addr,
  output word_t base,
  output word_t size,
  output logic  active,
  output logic  match
);
  logic [2:0]  fld;
  logic [RW:0] lim;

  always_comb begin
    fld    = bank_q[19:17];
    base   = bank_q & MSK_BASE;
    size   = (fld == 3'd7) ? '0 : (UNIT_SIZE << fld);
    active = bank_q[0] & glb_en;
    lim    = {1'b0, base} + {1'b0, size};
    match  = active && (size != '0) &&
             ({1'b0, req_addr} >= {1'b0, base}) &&
             ({1'b0, req_addr} < lim);
  end
endmodule

// File: rtl/sdcfg_prio.sv
module sdcfg_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  // isolate lowest set bit
  always_comb gnt = req & (~req + N'(1));
endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
  import sdcfg_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           acc_sel,
  input  logic                           acc_we,
  input  logic [31:0]                    acc_wdata,
  output logic [31:0]                    acc_rdata,
  input  logic [31:0]                    req_addr,
  output logic [NUM_BANKS-1:0][31:0]     bank_base,
  output logic [NUM_BANKS-1:0][31:0]     bank_size,
  output logic [NUM_BANKS-1:0]           bank_active,
  output logic [NUM_BANKS-1:0]           bank_hit,
  output logic [31:0]                    tmg_cfg,
  output logic                           ecc_irq
);
  localparam int BANK_STRIDE = 4;

  word_t addr_q, err0_q, err1_q, eaddr_q, cfg_q, stat_q;
  word_t rtr_q, pmit_q, tmg_q, eccc_q, ecce_q;
  logic  irq_q;
  word_t bank_q [NUM_BANKS];

  word_t err0_d, err1_d, cfg_d, stat_d, pmit_d, ecce_d;
  logic  irq_d;

  logic wr_ptr, wr_win;
  logic wr_err0, wr_err1, wr_eaddr, wr_cfg, wr_rtr, wr_pmit;
  logic wr_tmg, wr_eccc, wr_ecce;
  logic [NUM_BANKS-1:0] wr_bank;
  logic [NUM_BANKS-1:0] bank_match;

  // write decode
  always_comb begin
    wr_ptr   = acc_we & ~acc_sel;
    wr_win   = acc_we &  acc_sel;
    wr_err0  = wr_win && (addr_q == OFS_ERR0);
    wr_err1  = wr_win && (addr_q == OFS_ERR1);
    wr_eaddr = wr_win && (addr_q == OFS_EADDR);
    wr_cfg   = wr_win && (addr_q == OFS_CFG);
    wr_rtr   = wr_win && (addr_q == OFS_RTR);
    wr_pmit  = wr_win && (addr_q == OFS_PMIT);
    wr_tmg   = wr_win && (addr_q == OFS_TMG);
    wr_eccc  = wr_win && (addr_q == OFS_ECCC);
    wr_ecce  = wr_win && (addr_q == OFS_ECCE);
    for (int i = 0; i < NUM_BANKS; i++)
      wr_bank[i] = wr_win && (addr_q == OFS_BANK0 + word_t'(i * BANK_STRIDE));
  end

  // next-state values
  always_comb begin
    err0_d = err0_q & ~acc_wdata;
    err1_d = err1_q & ~acc_wdata;
    cfg_d  = acc_wdata & MSK_CFG;
    pmit_d = (acc_wdata & MSK_PMIT) | SET_PMIT;
    ecce_d = acc_wdata & MSK_ECCE;
    irq_d  = (ecce_d != '0);
    stat_d = stat_q;
    if (!cfg_q[EN_BIT] && cfg_d[EN_BIT])      stat_d[EN_BIT] = 1'b0;
    else if (cfg_q[EN_BIT] && !cfg_d[EN_BIT]) stat_d[EN_BIT] = 1'b1;
    if (!cfg_q[SLF_BIT] && cfg_d[SLF_BIT])      stat_d[SLF_BIT] = 1'b1;
    else if (cfg_q[SLF_BIT] && !cfg_d[SLF_BIT]) stat_d[SLF_BIT] = 1'b0;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      err0_q  <= '0;
      err1_q  <= '0;
      eaddr_q <= '0;
      cfg_q   <= RST_CFG;
      stat_q  <= '0;
      rtr_q   <= RST_RTR;
      pmit_q  <= RST_PMIT;
      tmg_q   <= RST_TMG;
      eccc_q  <= '0;
      ecce_q  <= '0;
      irq_q   <= 1'b0;
      for (int i = 0; i < NUM_BANKS; i++) bank_q[i] <= '0;
    end else begin
      if (wr_ptr)   addr_q  <= acc_wdata;
      if (wr_err0)  err0_q  <= err0_d;
      if (wr_err1)  err1_q  <= err1_d;
      if (wr_eaddr) eaddr_q <= acc_wdata;
      if (wr_cfg) begin
        cfg_q  <= cfg_d;
        stat_q <= stat_d;
      end
      if (wr_rtr)   rtr_q   <= acc_wdata & MSK_RTR;
      if (wr_pmit)  pmit_q  <= pmit_d;
      if (wr_tmg)   tmg_q   <= acc_wdata & MSK_TMG;
      if (wr_eccc)  eccc_q  <= acc_wdata & MSK_ECCC;
      if (wr_ecce) begin
        ecce_q <= ecce_d;
        irq_q  <= irq_d;
      end
      for (int i = 0; i < NUM_BANKS; i++)
        if (wr_bank[i]) bank_q[i] <= acc_wdata & MSK_BANK;
    end
  end

  // read mux
  always_comb begin
    acc_rdata = ALL_ONES;
    if (!acc_sel) begin
      acc_rdata = addr_q;
    end else begin
      case (addr_q)
        OFS_ERR0:  acc_rdata = err0_q;
        OFS_ERR1:  acc_rdata = err1_q;
        OFS_EADDR: acc_rdata = eaddr_q;
        OFS_CFG:   acc_rdata = cfg_q;
        OFS_STAT:  acc_rdata = stat_q;
        OFS_RTR:   acc_rdata = rtr_q;
        OFS_PMIT:  acc_rdata = pmit_q;
        OFS_ECCC:  acc_rdata = eccc_q;
        OFS_ECCE:  acc_rdata = ecce_q;
        default:   acc_rdata = ALL_ONES;
      endcase
      for (int i = 0; i < NUM_BANKS; i++)
        if (addr_q == OFS_BANK0 + word_t'(i * BANK_STRIDE)) acc_rdata = bank_q[i];
    end
  end

  // per-bank decode
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    sdcfg_bank_dec u_dec (
      .bank_q   (bank_q[g]),
      .glb_en   (cfg_q[EN_BIT]),
      .req_addr (req_addr),
      .base     (bank_base[g]),
      .size     (bank_size[g]),
      .active   (bank_active[g]),
      .match    (bank_match[g])
    );
  end

  sdcfg_prio #(.N(NUM_BANKS)) u_prio (
    .req (bank_match),
    .gnt (bank_hit)
  );

  assign tmg_cfg = tmg_q;
  assign ecc_irq = irq_q;
endmodule

// File: rtl/sdram_cfg_regs_chk.sv
module sdram_cfg_regs_chk
  import sdcfg_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 acc_sel,
  input logic                 acc_we,
  input logic [31:0]          acc_rdata,
  input logic [31:0]          addr_q,
  input logic [31:0]          cfg_q,
  input logic [31:0]          stat_q,
  input logic [31:0]          pmit_q,
  input logic [NUM_BANKS-1:0] bank_active,
  input logic [NUM_BANKS-1:0] bank_hit,
  input logic                 ecc_irq
);
  assert_hit_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_hit));
  assert_hit_in_active_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_hit & ~bank_active) == '0);
  assert_active_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_active) |-> cfg_q[EN_BIT]);
  assert_en_rise_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_q[EN_BIT]) |-> !stat_q[EN_BIT]);
  assert_en_fall_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_q[EN_BIT]) |-> stat_q[EN_BIT]);
  assert_slf_rise_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_q[SLF_BIT]) |-> stat_q[SLF_BIT]);
  assert_pmit_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pmit_q[26:22] == 5'h1F);
  assert_irq_rise_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ecc_irq) |-> $past(acc_we && acc_sel && addr_q == OFS_ECCE));
  assert_irq_fall_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ecc_irq) |-> $past(acc_we && acc_sel && addr_q == OFS_ECCE));
  assert_tmg_read_ones_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_sel && addr_q == OFS_TMG) |-> acc_rdata == ALL_ONES);
endmodule

bind sdram_cfg_regs sdram_cfg_regs_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_sel     (acc_sel),
  .acc_we      (acc_we),
  .acc_rdata   (acc_rdata),
  .addr_q      (addr_q),
  .cfg_q       (cfg_q),
  .stat_q      (stat_q),
  .pmit_q      (pmit_q),
  .bank_active (bank_active),
  .bank_hit    (bank_hit),
  .ecc_irq     (ecc_irq)
);

// File: tb/sdram_cfg_regs_tb.sv
module sdram_cfg_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;

  logic               clk;
  logic               rst_n;
  logic               acc_sel;
  logic               acc_we;
  logic [31:0]        acc_wdata;
  logic [31:0]        acc_rdata;
  logic [31:0]        req_addr;
  logic [NB-1:0][31:0] bank_base;
  logic [NB-1:0][31:0] bank_size;
  logic [NB-1:0]      bank_active;
  logic [NB-1:0]      bank_hit;
  logic [31:0]        tmg_cfg;
  logic               ecc_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  sdram_cfg_regs #(.NUM_BANKS(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_sel(acc_sel), .acc_we(acc_we),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .req_addr(req_addr),
    .bank_base(bank_base), .bank_size(bank_size), .bank_active(bank_active),
    .bank_hit(bank_hit), .tmg_cfg(tmg_cfg), .ecc_irq(ecc_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    acc_sel = sel; acc_we = 1'b1; acc_wdata = d;
    @(negedge clk);
    acc_we = 1'b0;
  endtask

  task automatic wr_reg(input logic [31:0] ofs, input logic [31:0] d);
    wr(1'b0, ofs);
    wr(1'b1, d);
  endtask

  task automatic rd_reg(input logic [31:0] ofs, output logic [31:0] v);
    wr(1'b0, ofs);
    acc_sel = 1'b1;
    #1 v = acc_rdata;
  endtask

  task automatic chk_reg(input string tag, input logic [31:0] ofs, input logic [31:0] exp);
    logic [31:0] v;
    rd_reg(ofs, v);
    check(tag, v, exp);
  endtask

  task automatic t_reset;
    #1;
    check("R1 ptr", acc_rdata, 32'h0);
    check("R1 tmg_cfg", tmg_cfg, 32'h0085_4009);
    check("R1 irq", {31'b0, ecc_irq}, 32'h0);
    check("R1 active", {28'b0, bank_active}, 32'h0);
    chk_reg("R1 cfg", 32'h20, 32'h0080_0000);
    chk_reg("R1 rtr", 32'h30, 32'h05F0_0000);
    chk_reg("R1 pmit", 32'h34, 32'h07C0_0000);
    chk_reg("R1 status", 32'h24, 32'h0);
    chk_reg("R1 eaddr", 32'h10, 32'h0);
    chk_reg("R1 ecce", 32'h98, 32'h0);
  endtask

  task automatic t_pointer;
    wr(1'b0, 32'h0000_0094);
    acc_sel = 1'b0;
    #1 check("R2 ptr readback", acc_rdata, 32'h0000_0094);
    wr_reg(32'h94, 32'h00A0_0000);
    chk_reg("R2 window eccc", 32'h94, 32'h00A0_0000);
  endtask

  task automatic t_err_regs;
    wr_reg(32'h10, 32'h1234_5678);
    chk_reg("R3 eaddr direct", 32'h10, 32'h1234_5678);
    wr_reg(32'h00, 32'hFFFF_FFFF);
    chk_reg("R3 err0 w1c", 32'h00, 32'h0);
    wr_reg(32'h08, 32'hFFFF_FFFF);
    chk_reg("R3 err1 w1c", 32'h08, 32'h0);
    wr_reg(32'h24, 32'hFFFF_FFFF);
    chk_reg("R3 status ro", 32'h24, 32'h0);
    wr_reg(32'h04, 32'h0000_0000);
    chk_reg("R3 undef write eaddr", 32'h10, 32'h1234_5678);
    chk_reg("R3 undef write cfg", 32'h20, 32'h0080_0000);
  endtask

  task automatic t_cfg_status;
    wr_reg(32'h20, 32'hFFFF_FFFF);
    chk_reg("R4 cfg mask", 32'h20, 32'hFFE0_0000);
    chk_reg("R5 R6 rise status", 32'h24, 32'h4000_0000);
    wr_reg(32'h20, 32'h0);
    chk_reg("R5 R6 fall status", 32'h24, 32'h8000_0000);
    wr_reg(32'h20, 32'h8000_0000);
    chk_reg("R5 en rise clears", 32'h24, 32'h0);
    wr_reg(32'h20, 32'h4000_0000);
    chk_reg("R6 slf only status", 32'h24, 32'hC000_0000);
    wr_reg(32'h20, 32'h0);
    chk_reg("R6 slf fall", 32'h24, 32'h8000_0000);
  endtask

  task automatic t_banks;
    wr_reg(32'h40, 32'hFFFF_FFFF);
    chk_reg("R7 bank mask", 32'h40, 32'hFFDE_E001);
    wr_reg(32'h40, 32'h0002_0001);
    wr_reg(32'h44, 32'h0080_0001);
    wr_reg(32'h48, 32'h010E_0001);
    wr_reg(32'h4C, 32'h0004_0001);
    #1;
    check("R7 base1", bank_base[1], 32'h0080_0000);
    check("R7 base2", bank_base[2], 32'h0100_0000);
    check("R7 size0", bank_size[0], 32'h0080_0000);
    check("R7 size1", bank_size[1], 32'h0040_0000);
    check("R7 size2 invalid", bank_size[2], 32'h0);
    check("R7 size3", bank_size[3], 32'h0100_0000);
    check("R8 inactive when disabled", {28'b0, bank_active}, 32'h0);
    wr_reg(32'h20, 32'h8000_0000);
    #1 check("R8 active when enabled", {28'b0, bank_active}, 32'hF);
  endtask

  task automatic t_hits;
    req_addr = 32'h0010_0000; #1 check("R12 overlap lowest", {28'b0, bank_hit}, 32'h1);
    req_addr = 32'h0090_0000; #1 check("R12 bank1 over bank3", {28'b0, bank_hit}, 32'h2);
    req_addr = 32'h00BF_FFFF; #1 check("R12 bank1 last byte", {28'b0, bank_hit}, 32'h2);
    req_addr = 32'h00C0_0000; #1 check("R12 bank3 only", {28'b0, bank_hit}, 32'h8);
    req_addr = 32'h0100_0000; #1 check("R12 end excl size0", {28'b0, bank_hit}, 32'h0);
    wr_reg(32'h44, 32'h0080_0000);
    #1 check("R8 valid cleared", {28'b0, bank_active}, 32'hD);
    req_addr = 32'h0090_0000; #1 check("R12 skip invalid", {28'b0, bank_hit}, 32'h8);
  endtask

  task automatic t_same_cycle;
    logic [31:0] v;
    req_addr = 32'h0010_0000;
    wr(1'b0, 32'h20);
    @(negedge clk);
    acc_sel = 1'b1; acc_we = 1'b1; acc_wdata = 32'h0;
    #1 check("R8 hit during write", {28'b0, bank_hit}, 32'h1);
    @(negedge clk);
    acc_we = 1'b0;
    #1 check("R8 hit after disable", {28'b0, bank_hit}, 32'h0);
    check("R8 active after disable", {28'b0, bank_active}, 32'h0);
    rd_reg(32'h24, v);
    check("R5 status after disable", v, 32'h8000_0000);
  endtask

  task automatic t_masks;
    wr_reg(32'h30, 32'hFFFF_FFFF);
    chk_reg("R9 rtr", 32'h30, 32'h3FF8_0000);
    wr_reg(32'h34, 32'h0);
    chk_reg("R9 pmit zero", 32'h34, 32'h07C0_0000);
    wr_reg(32'h34, 32'hFFFF_FFFF);
    chk_reg("R9 pmit ones", 32'h34, 32'hFFC0_0000);
    wr_reg(32'h80, 32'hFFFF_FFFF);
    #1 check("R9 tmg_cfg", tmg_cfg, 32'h018F_C01F);
    chk_reg("R11 tmg read", 32'h80, 32'hFFFF_FFFF);
    wr_reg(32'h94, 32'hFFFF_FFFF);
    chk_reg("R9 eccc", 32'h94, 32'h00F0_0000);
    chk_reg("R11 undef read", 32'h04, 32'hFFFF_FFFF);
    chk_reg("R11 undef read 0x50", 32'h50, 32'hFFFF_FFFF);
  endtask

  task automatic t_ecc;
    wr_reg(32'h98, 32'h000F_0FFF);
    #1 check("R10 masked zero irq", {31'b0, ecc_irq}, 32'h0);
    chk_reg("R10 masked zero", 32'h98, 32'h0);
    wr(1'b0, 32'h98);
    @(negedge clk);
    acc_sel = 1'b1; acc_we = 1'b1; acc_wdata = 32'h0000_1000;
    #1 check("R10 irq not yet", {31'b0, ecc_irq}, 32'h0);
    @(negedge clk);
    acc_we = 1'b0;
    #1 check("R10 irq rise", {31'b0, ecc_irq}, 32'h1);
    wr_reg(32'h98, 32'h8000_0000);
    #1 check("R10 irq stays", {31'b0, ecc_irq}, 32'h1);
    chk_reg("R10 ecce value", 32'h98, 32'h8000_0000);
    wr_reg(32'h98, 32'h0);
    #1 check("R10 irq fall", {31'b0, ecc_irq}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_sel = 1'b0; acc_we = 1'b0; acc_wdata = '0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pointer();
    t_err_regs();
    t_cfg_status();
    t_banks();
    t_hits();
    t_same_cycle();
    t_masks();
    t_ecc();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule